// File: doc/BRIEF.md
# Chip-Select Framed Serial Word Port

This block is the slave-side front end of a three-wire serial link with chip select. A host pulls the select line low, clocks in a 16-bit word least significant bit first, and raises select again. On the rising edge of select the block hands the complete word to the command logic, together with a single-cycle execute strobe. The strobe fires only when the frame held exactly 16 serial clock rises. The serial clock, data and select inputs are all sampled in a faster system clock domain. Each passes through a synchronizer and an edge detector, so the serial clock is never used as a clock.

The serial output always presents bit 0 of the shift register and moves to the next bit after each falling edge of the serial clock. During a frame the host therefore receives the previous 16-bit contents of the register, which lets several ports share one chain. When select is high the output enable is released.

When the command logic decides that the word it just executed was a readback request, it pulses a load request. At the next falling edge of select, the block copies the 12 parallel pin values into bits 15:4 of the register and leaves bits 3:0 as they were. The host then finds the pin data in serial positions 5 to 16 of that frame. Reset clears the upper byte of the register, leaves the lower byte untouched, and drops any pending load.

Top module: `serial_frame_port`

## Requirements
- R1: Serial clock rises that occur while select is high do not change the shift register. This is seen in the next frame's readout.
- R2: While select is low, each serial clock rise shifts the data input into bit 15 and moves the rest of the register down by one. After 16 rises the first bit sent sits in bit 0 and the last in bit 15.
- R3: The serial output carries bit 0 of the register. It is updated at select fall and after every serial clock fall. Over a 16-rise frame the host therefore reads, in order, bits 0 to 15 of the register as it stood when select fell.
- R4: The output enable is low while select is high and high while select is low, with a lag of a few system cycles.
- R5: A select rise that ends a frame of exactly 16 serial clock rises gives one system-cycle pulse on `cmd_valid_o`, with `cmd_word_o` holding the register contents.
- R6: A frame with any other number of serial clock rises (for example 15 or 17) gives no execute pulse.
- R7: After a `load_req_i` pulse, the next select fall loads `pin_data_i[11:0]` into register bits 15:4 and keeps bits 3:0. The request is used once and has no effect on later frames.
- R8: Reset clears register bits 15:8, keeps bits 7:0, cancels a pending load, and drives `cmd_valid_o` and `ser_dout_en_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock from the host |
| ser_din_i | input | 1 | Serial data in, least significant bit first |
| ser_sel_n_i | input | 1 | Frame select, active low |
| ser_dout_o | output | 1 | Serial data out (register bit 0) |
| ser_dout_en_o | output | 1 | Output enable for the serial data pad; low means high impedance |
| pin_data_i | input | PIN_W | Parallel pin values for readback capture |
| load_req_i | input | 1 | One-cycle request to capture pins at the next select fall |
| cmd_valid_o | output | 1 | Execute strobe, one system cycle |
| cmd_word_o | output | WORD_W | Word handed to command logic |

## Verification
The bench runs frames of 15, 16 and 17 rises. A port that counted wrongly or ignored the count would pulse on the short or long frames, or stay silent on the full ones. Every frame's readout is compared with a shift model of the register, so a reversed bit order, an output that moved on the rising edge, or a load that landed in the wrong bits or overwrote bits 3:0 shows up as a mismatched readout. Directed cases toggle the serial clock while select is high, check that a load request is used for one frame only, and apply reset between a write and a readback to confirm that only the upper byte is cleared.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  // Synchronized view of one asynchronous input
  typedef struct packed {
    logic level;
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           din,
  output sfp_pkg::edge_t ev
);
  // STAGES metastability flops plus one history flop for edge detection
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {(STAGES+1){RST_VAL}};
    else     chain <= {chain[STAGES-1:0], din};
  end

  always_comb begin
    ev.level = chain[STAGES-1];
    ev.rise  = chain[STAGES-1] & ~chain[STAGES];
    ev.fall  = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/sfp_shifter.sv
module sfp_shifter #(
  parameter int WORD_W = 16,
  parameter int PIN_W  = 12,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              din,
  input  logic              frame_start,
  input  logic              load_en,
  input  logic [PIN_W-1:0]  pins,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  count
);
  localparam int HI_W   = WORD_W / 2;
  localparam int LO_W   = WORD_W - HI_W;
  localparam int KEEP_W = WORD_W - PIN_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [HI_W-1:0]   hi_q;
  logic [LO_W-1:0]   lo_q;
  logic [WORD_W-1:0] nxt;

  assign word = {hi_q, lo_q};

  always_comb begin
    nxt = word;
    if (frame_start && load_en)
      nxt = {pins, word[KEEP_W-1:0]};
    else if (shift_en)
      nxt = {din, word[WORD_W-1:1]};
  end

  // Upper half is cleared by reset
  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else     hi_q <= nxt[WORD_W-1:LO_W];
  end

  // Lower half keeps its contents across reset
  always_ff @(posedge clk) begin
    if (!rst) lo_q <= nxt[LO_W-1:0];
  end

  // Rising-edge counter, saturating so long frames never wrap to a match
  always_ff @(posedge clk) begin
    if (rst || frame_start)          count <= '0;
    else if (shift_en && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              so_update,
  input  logic              load_req,
  input  logic [CNT_W-1:0]  count,
  input  logic [WORD_W-1:0] word,
  output logic              load_en,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  output logic              dout,
  output logic              dout_en
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic pending;

  // Readback capture request, consumed by the next frame start
  always_ff @(posedge clk) begin
    if (rst || frame_start) pending <= 1'b0;
    else if (load_req)      pending <= 1'b1;
  end
  assign load_en = pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      cmd_valid <= frame_end && (count == FULL);
      if (frame_end) cmd_word <= word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= 1'b0;
      dout_en <= 1'b0;
    end else begin
      dout_en <= active;
      if (frame_start || so_update) dout <= word[0];
    end
  end
endmodule

// File: rtl/serial_frame_port.sv
module serial_frame_port #(
  parameter int WORD_W      = 16,
  parameter int PIN_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_din_i,
  input  logic              ser_sel_n_i,
  output logic              ser_dout_o,
  output logic              ser_dout_en_o,
  input  logic [PIN_W-1:0]  pin_data_i,
  input  logic              load_req_i,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_word_o
);
  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam int N_IN  = 3;
  localparam int I_CLK = 0;
  localparam int I_DIN = 1;
  localparam int I_SEL = 2;
  localparam logic [N_IN-1:0] IDLE = 3'b100;

  logic [N_IN-1:0] raw;
  sfp_pkg::edge_t  ev [N_IN];

  assign raw = {ser_sel_n_i, ser_din_i, ser_clk_i};

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    sfp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE[g])) u_sync (
      .clk(clk), .rst(rst), .din(raw[g]), .ev(ev[g])
    );
  end

  logic              active, shift_en, so_update, frame_start, frame_end, load_en;
  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  count;

  assign active      = ~ev[I_SEL].level;
  assign shift_en    = ev[I_CLK].rise & active;
  assign so_update   = ev[I_CLK].fall & active;
  assign frame_start = ev[I_SEL].fall;
  assign frame_end   = ev[I_SEL].rise;

  sfp_shifter #(.WORD_W(WORD_W), .PIN_W(PIN_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(ev[I_DIN].level),
    .frame_start(frame_start), .load_en(load_en), .pins(pin_data_i),
    .word(word), .count(count)
  );

  sfp_ctrl #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .active(active), .frame_start(frame_start),
    .frame_end(frame_end), .so_update(so_update), .load_req(load_req_i),
    .count(count), .word(word), .load_en(load_en),
    .cmd_valid(cmd_valid_o), .cmd_word(cmd_word_o),
    .dout(ser_dout_o), .dout_en(ser_dout_en_o)
  );
endmodule

// File: rtl/sfp_chk.sv
module sfp_chk #(
  parameter int WORD_W = 16,
  parameter int PIN_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_clk_i,
  input logic              ser_din_i,
  input logic              ser_sel_n_i,
  input logic              ser_dout_o,
  input logic              ser_dout_en_o,
  input logic [PIN_W-1:0]  pin_data_i,
  input logic              load_req_i,
  input logic              cmd_valid_o,
  input logic [WORD_W-1:0] cmd_word_o
);
  // R4
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    (ser_sel_n_i && $past(ser_sel_n_i) && $past(ser_sel_n_i,2) && $past(ser_sel_n_i,3))
      |-> !ser_dout_en_o);

  // R4
  en_on_chk: assert property (@(posedge clk) disable iff (rst)
    (!ser_sel_n_i && !$past(ser_sel_n_i) && !$past(ser_sel_n_i,2) && !$past(ser_sel_n_i,3)
     && !$past(rst) && !$past(rst,2) && !$past(rst,3))
      |-> ser_dout_en_o);

  // R3
  dout_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((ser_clk_i == $past(ser_clk_i)) && ($past(ser_clk_i) == $past(ser_clk_i,2)) &&
     ($past(ser_clk_i,2) == $past(ser_clk_i,3)) && ($past(ser_clk_i,3) == $past(ser_clk_i,4)) &&
     (ser_sel_n_i == $past(ser_sel_n_i)) && ($past(ser_sel_n_i) == $past(ser_sel_n_i,2)) &&
     ($past(ser_sel_n_i,2) == $past(ser_sel_n_i,3)) && ($past(ser_sel_n_i,3) == $past(ser_sel_n_i,4)))
      |-> $stable(ser_dout_o));

  // R5
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |=> !cmd_valid_o);

  // R5
  strobe_closed_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid_o |-> !ser_dout_en_o);

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!cmd_valid_o && !ser_dout_en_o));
endmodule

bind serial_frame_port sfp_chk #(.WORD_W(WORD_W), .PIN_W(PIN_W)) u_chk (.*);

// File: tb/sim_serial_frame_port.sv
module sim_serial_frame_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_clk_i = 1'b0, ser_din_i = 1'b0, ser_sel_n_i = 1'b1;
  logic        ser_dout_o, ser_dout_en_o;
  logic [11:0] pin_data_i = '0;
  logic        load_req_i = 1'b0;
  logic        cmd_valid_o;
  logic [15:0] cmd_word_o;

  serial_frame_port u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  logic [15:0] last_word;

  // model of the register and which of its bits are known
  logic [15:0] m = '0, known = 16'hFF00;
  logic        pend = 1'b0;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung actual=%0d expected<150000", cyc);
      summary();
      $finish;
    end
  end

  always @(negedge clk) if (!rst && cmd_valid_o) begin
    pulses++;
    last_word = cmd_word_o;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One frame of n serial clock rises; checks readout, enable and strobe
  task automatic frame(input logic [15:0] w, input int n);
    logic [15:0] rd = '0, exp = '0, msk = '0;
    int p0 = pulses;
    if (pend) begin
      m[15:4] = pin_data_i;
      known[15:4] = '1;
      pend = 1'b0;
    end
    ser_sel_n_i = 1'b0;
    wt(8);
    chk("R4 enable while selected", {31'b0, ser_dout_en_o}, 32'd1);
    for (int i = 0; i < n; i++) begin
      ser_din_i = w[i % 16];
      wt(4);
      if (i < 16) begin
        rd[i] = ser_dout_o; exp[i] = m[0]; msk[i] = known[0];
      end
      m = {w[i % 16], m[15:1]};
      known = {1'b1, known[15:1]};
      ser_clk_i = 1'b1; wt(8);
      ser_clk_i = 1'b0; wt(4);
    end
    wt(4);
    chk("R3 readout of prior contents", {16'b0, rd & msk}, {16'b0, exp & msk});
    ser_sel_n_i = 1'b1;
    wt(8);
    chk("R4 enable released", {31'b0, ser_dout_en_o}, 32'd0);
    if (n == 16) begin
      chk("R5 one strobe for full frame", pulses - p0, 32'd1);
      chk("R2 word order", {16'b0, last_word}, {16'b0, w});
    end else begin
      chk("R6 no strobe for wrong count", pulses - p0, 32'd0);
    end
  endtask

  task automatic request_load();
    load_req_i = 1'b1; wt(1); load_req_i = 1'b0; wt(2);
    pend = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    wt(5);
    chk("R8 strobe low in reset", {31'b0, cmd_valid_o}, 32'd0);
    chk("R8 enable low in reset", {31'b0, ser_dout_en_o}, 32'd0);
    rst = 1'b0;
    wt(5);
    // first frame reads out upper byte cleared by reset
    frame(16'h3C5A, 16);
    frame(16'hFFFF, 16);
    frame(16'h0001, 16);

    // R1: clock activity while deselected is ignored
    for (int k = 0; k < 6; k++) begin
      ser_din_i = k[0];
      ser_clk_i = 1'b1; wt(8); ser_clk_i = 1'b0; wt(8);
    end
    frame(16'h8000, 16);   // readout must still be 0x0001 (R1)

    // R6: short and long frames
    frame(16'h1234, 15);
    frame(16'hBEEF, 17);
    frame(16'hC0DE, 16);

    // R7: readback capture, used once
    pin_data_i = 12'hA5B;
    request_load();
    frame(16'h0F0F, 16);   // readout = pins in 15:4, C0DE[3:0] kept
    pin_data_i = 12'h123;
    frame(16'h7777, 16);   // no capture now (R7 used once)

    // R8: reset keeps low byte, clears upper byte, drops pending load
    frame(16'hA5C3, 16);
    request_load();
    rst = 1'b1; wt(3);
    chk("R8 strobe low after reset", {31'b0, cmd_valid_o}, 32'd0);
    rst = 1'b0; wt(4);
    m[15:8] = 8'h00; pend = 1'b0;
    frame(16'h4242, 16);   // expects 0x00C3

    // random mix
    for (int t = 0; t < 40; t++) begin
      int r = $urandom % 8;
      int n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      pin_data_i = 12'($urandom);
      frame(16'($urandom), n);
      if (n == 16 && ($urandom % 3 == 0)) request_load();
    end

    summary();
    $finish;
  end
endmodule